// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block puts a small direct-mapped cache in front of a 2 KiB byte-wide backing store, and the store is part of the block. A requester sends one byte read or one byte write at a time with an 11-bit address. For each access the block returns a data byte and a flag that says whether the line was already present. The cache has 16 lines of 16 bytes. Writes are kept in the cache and reach the store only when a modified line is evicted. A write to an absent line first fetches that line.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle with no response pending, so at most one access is in flight. While an access waits for a response, further requests are back-pressured. A response stays on `rsp_valid` with stable `rsp_rdata` and `rsp_hit` until the requester raises `rsp_ready`. A victim write-back or a line fill moves one byte per clock.

A debug port takes a line number and returns that line's valid bit, dirty bit, tag and 16 data bytes, combinationally. It does not change any state.

Top module: `dm_byte_cache`

## Requirements
- R1: Address bits [3:0] select the byte within a line, bits [7:4] select one of 16 lines, and bits [10:8] are the 3-bit tag stored with the line. For example, 0x7A2 lands in line 0xA with tag 7, and 0x3D5 lands in line 0xD with tag 3.
- R2: After reset, every store byte holds the low 8 bits of its own address, and every line has valid, dirty, tag and all data bytes at zero.
- R3: A read to a present line returns the stored byte with `rsp_hit`=1. `rsp_valid` rises on the first clock edge after the accepting edge.
- R4: A read to an absent line replaces a clean or invalid line with all 16 bytes from the store. It returns the byte with `rsp_hit`=0, and the response comes 18 edges after acceptance.
- R5: A write to an absent line fetches the whole line, then updates the byte in the cache. It reports `rsp_hit`=0, returns the written byte on `rsp_rdata`, and leaves the line dirty.
- R6: A write to a present line updates only the cache copy, marks the line dirty, returns the written byte and reports `rsp_hit`=1 after 1 edge.
- R7: A miss that replaces a valid dirty line first writes that line's 16 bytes back to the store, at the address rebuilt from its tag and line number. It then fills the new line, and the response comes 34 edges after acceptance. Later reads of the victim's addresses return the written values.
- R8: A fill sets the line valid, stores the new tag and clears dirty.
- R9: `req_ready` is high exactly when the block is idle with no response pending. A request is taken on an edge where `req_valid` and `req_ready` are both high. While `rsp_ready` is low, the response holds with stable data and hit flag, and no new request is taken.
- R10: The debug port returns, for line `dbg_line`, its valid bit, dirty bit, tag and data. Byte k of the line sits at `dbg_data[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 8 | Byte read, or byte written |
| rsp_hit | output | 1 | 1 = line was present |
| dbg_line | input | 4 | Line number to inspect |
| dbg_valid | output | 1 | Valid bit of that line |
| dbg_dirty | output | 1 | Dirty bit of that line |
| dbg_tag | output | 3 | Tag of that line |
| dbg_data | output | 128 | Data bytes of that line |

## Verification
The bench builds the block with its default parameters: 11 address bits, 4 offset bits and 4 line-index bits. With these values the whole 2048-byte store can be swept. It reads every address, checks the reset pattern and every clean fill, and times each hit and miss. It then writes every address in an odd-stride order, which produces write hits, clean write misses and dirty evictions. It follows this with a read sweep in the opposite direction and a debug readout of all 16 lines. Together these prove that write-back preserved every byte, and they measure the wait before each response and check that the response holds while `rsp_ready` is low.

// File: rtl/bcache_pkg.sv
package bcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } ctrl_state_t;

endpackage

// File: rtl/byte_store.sv
module byte_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  // reset loads each byte with the low byte of its own address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= a[7:0];
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/line_array.sv
module line_array #(
  parameter int OFF_W = 4,
  parameter int IDX_W = 4,
  parameter int TAG_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_W-1:0]         idx,
  input  logic [OFF_W-1:0]         lk_off,
  output logic                     lk_valid,
  output logic                     lk_dirty,
  output logic [TAG_W-1:0]         lk_tag,
  output logic [7:0]               lk_byte,
  input  logic                     fill_we,
  input  logic [OFF_W-1:0]         fill_off,
  input  logic [7:0]               fill_byte,
  input  logic                     fill_done,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic                     cpu_we,
  input  logic [OFF_W-1:0]         cpu_off,
  input  logic [7:0]               cpu_byte,
  input  logic [IDX_W-1:0]         dbg_idx,
  output logic                     dbg_valid,
  output logic                     dbg_dirty,
  output logic [TAG_W-1:0]         dbg_tag,
  output logic [8*(1<<OFF_W)-1:0]  dbg_data
);
  localparam int NB = 1 << OFF_W;
  localparam int NL = 1 << IDX_W;

  logic [NL-1:0]    valid_q;
  logic [NL-1:0]    dirty_q;
  logic [TAG_W-1:0] tag_q  [NL];
  logic [7:0]       data_q [NL][NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int l = 0; l < NL; l++) begin
        tag_q[l] <= '0;
        for (int b = 0; b < NB; b++) data_q[l][b] <= '0;
      end
    end else begin
      if (fill_we) data_q[idx][fill_off] <= fill_byte;
      if (cpu_we)  data_q[idx][cpu_off]  <= cpu_byte;
      if (fill_done) begin
        valid_q[idx] <= 1'b1;
        tag_q[idx]   <= fill_tag;
        dirty_q[idx] <= 1'b0;
      end
      if (cpu_we) dirty_q[idx] <= 1'b1;
    end
  end

  assign lk_valid = valid_q[idx];
  assign lk_dirty = dirty_q[idx];
  assign lk_tag   = tag_q[idx];
  assign lk_byte  = data_q[idx][lk_off];

  assign dbg_valid = valid_q[dbg_idx];
  assign dbg_dirty = dirty_q[dbg_idx];
  assign dbg_tag   = tag_q[dbg_idx];

  for (genvar g = 0; g < NB; g++) begin : g_dbg_byte
    assign dbg_data[8*g +: 8] = data_q[dbg_idx][g];
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import bcache_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  lk_off,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [7:0]        lk_byte,
  output logic              fill_we,
  output logic [OFF_W-1:0]  fill_off,
  output logic [7:0]        fill_byte,
  output logic              fill_done,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              cpu_we,
  output logic [OFF_W-1:0]  cpu_off,
  output logic [7:0]        cpu_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata
);
  localparam logic [OFF_W-1:0] CNT_LAST = '1;

  ctrl_state_t       state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              miss_q;
  logic [7:0]        rdata_q;
  logic              hit_q;

  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_line;
  logic [TAG_W-1:0] a_tag;
  logic             present;

  assign a_off   = addr_q[OFF_W-1:0];
  assign a_line  = addr_q[OFF_W +: IDX_W];
  assign a_tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign present = lk_valid && (lk_tag == a_tag);

  assign idx    = a_line;
  assign lk_off = (state_q == ST_WBACK) ? cnt_q : a_off;

  // victim bytes go back to the address rebuilt from the stored tag
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_waddr = {lk_tag, a_line, cnt_q};
  assign mem_wdata = lk_byte;

  assign mem_raddr = {a_tag, a_line, cnt_q};
  assign fill_we   = (state_q == ST_FILL);
  assign fill_off  = cnt_q;
  assign fill_byte = mem_rdata;
  assign fill_done = (state_q == ST_FILL) && (cnt_q == CNT_LAST);
  assign fill_tag  = a_tag;

  assign cpu_we   = (state_q == ST_CHECK) && present && wr_q;
  assign cpu_off  = a_off;
  assign cpu_byte = wdata_q;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_hit   = hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      miss_q  <= 1'b0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (present) begin
            rdata_q <= wr_q ? wdata_q : lk_byte;
            hit_q   <= !miss_q;
            state_q <= ST_RESP;
          end else begin
            miss_q  <= 1'b1;
            cnt_q   <= '0;
            state_q <= (lk_valid && lk_dirty) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= ST_FILL;
        end
        ST_FILL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= ST_CHECK;
        end
        ST_RESP: begin
          if (rsp_ready) begin
            miss_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_byte_cache.sv
module dm_byte_cache #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [7:0]                      req_wdata,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [7:0]                      rsp_rdata,
  output logic                            rsp_hit,
  input  logic [IDX_W-1:0]                dbg_line,
  output logic                            dbg_valid,
  output logic                            dbg_dirty,
  output logic [ADDR_W-OFF_W-IDX_W-1:0]   dbg_tag,
  output logic [8*(1<<OFF_W)-1:0]         dbg_data
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  lk_off;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [7:0]        lk_byte;
  logic              fill_we, fill_done, cpu_we, mem_we;
  logic [OFF_W-1:0]  fill_off, cpu_off;
  logic [7:0]        fill_byte, cpu_byte, mem_wdata, mem_rdata;
  logic [TAG_W-1:0]  fill_tag;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;

  cache_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .idx(idx), .lk_off(lk_off), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .lk_tag(lk_tag), .lk_byte(lk_byte),
    .fill_we(fill_we), .fill_off(fill_off), .fill_byte(fill_byte),
    .fill_done(fill_done), .fill_tag(fill_tag),
    .cpu_we(cpu_we), .cpu_off(cpu_off), .cpu_byte(cpu_byte),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  line_array #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .idx(idx), .lk_off(lk_off), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .lk_tag(lk_tag), .lk_byte(lk_byte),
    .fill_we(fill_we), .fill_off(fill_off), .fill_byte(fill_byte),
    .fill_done(fill_done), .fill_tag(fill_tag),
    .cpu_we(cpu_we), .cpu_off(cpu_off), .cpu_byte(cpu_byte),
    .dbg_idx(dbg_line), .dbg_valid(dbg_valid), .dbg_dirty(dbg_dirty),
    .dbg_tag(dbg_tag), .dbg_data(dbg_data)
  );

  byte_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/byte_cache_chk.sv
module byte_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       rsp_hit,
  input logic       mem_we,
  input logic       fill_done,
  input logic       cpu_we
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit));

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R3
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_hit |-> $past(req_valid && req_ready, 2));

  // R7
  wback_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready && !rsp_valid && !cpu_we);

  // R8
  fill_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !rsp_valid && !mem_we);
endmodule

bind dm_byte_cache byte_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_hit(rsp_hit), .mem_we(mem_we), .fill_done(fill_done), .cpu_we(cpu_we)
);

// File: tb/dm_byte_cache_bench.sv
`timescale 1ns/1ps
module dm_byte_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [10:0]  req_addr = '0;
  logic [7:0]   req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [7:0]   rsp_rdata;
  logic         rsp_hit;
  logic [3:0]   dbg_line = '0;
  logic         dbg_valid, dbg_dirty;
  logic [2:0]   dbg_tag;
  logic [127:0] dbg_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] ref_mem [2048];
  logic       m_valid [16];
  logic       m_dirty [16];
  logic [2:0] m_tag   [16];

  always #10 clk = ~clk;

  dm_byte_cache u_dm_byte_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .dbg_line(dbg_line), .dbg_valid(dbg_valid), .dbg_dirty(dbg_dirty),
    .dbg_tag(dbg_tag), .dbg_data(dbg_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R10 / R2 / R1: compare one line through the debug port against the model
  task automatic chk_line(input int l, input string req);
    @(negedge clk);
    dbg_line = l[3:0];
    #1;
    chk(req, $sformatf("line %0h valid", l), int'(dbg_valid), int'(m_valid[l]));
    chk(req, $sformatf("line %0h dirty", l), int'(dbg_dirty), int'(m_dirty[l]));
    chk(req, $sformatf("line %0h tag", l), int'(dbg_tag), int'(m_tag[l]));
    for (int k = 0; k < 16; k++) begin
      logic [7:0] e;
      e = m_valid[l] ? ref_mem[{m_tag[l], l[3:0], k[3:0]}] : 8'h00;
      chk(req, $sformatf("line %0h byte %0h", l, k), int'(dbg_data[8*k +: 8]), int'(e));
    end
  endtask

  task automatic access(input bit wr, input logic [10:0] a, input logic [7:0] wd, input int hold);
    logic [3:0] ln;
    logic [2:0] tg;
    bit         e_hit;
    int         e_lat;
    logic [7:0] e_data;
    string      req;
    int         lat;
    logic [7:0] seen;
    ln     = a[7:4];
    tg     = a[10:8];
    e_hit  = m_valid[ln] && (m_tag[ln] == tg);
    e_lat  = e_hit ? 1 : ((m_valid[ln] && m_dirty[ln]) ? 34 : 18);
    e_data = wr ? wd : ref_mem[a];
    if (!e_hit && m_valid[ln] && m_dirty[ln]) req = "R7";
    else if (wr) req = e_hit ? "R6" : "R5";
    else req = e_hit ? "R3" : "R4";
    if (!e_hit) begin
      m_valid[ln] = 1'b1;
      m_tag[ln]   = tg;
      m_dirty[ln] = 1'b0;
    end
    if (wr) begin
      ref_mem[a]  = wd;
      m_dirty[ln] = 1'b1;
    end

    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(req, $sformatf("latency @%0h", a), lat, e_lat);
    chk(req, $sformatf("hit @%0h", a), int'(rsp_hit), int'(e_hit));
    chk(req, $sformatf("data @%0h", a), int'(rsp_rdata), int'(e_data));
    seen = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9", "rsp_valid held", int'(rsp_valid), 1);
      chk("R9", "req_ready low while held", int'(req_ready), 0);
      chk("R9", "data stable while held", int'(rsp_rdata), int'(seen));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    if (hold > 0) chk("R9", "ready after release", int'(req_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=0 expected=1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 2048; a++) ref_mem[a] = a[7:0];
    for (int l = 0; l < 16; l++) begin
      m_valid[l] = 1'b0;
      m_dirty[l] = 1'b0;
      m_tag[l]   = 3'd0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R9: reset state
    chk("R9", "req_ready after reset", int'(req_ready), 1);
    chk("R9", "rsp_valid after reset", int'(rsp_valid), 0);
    for (int l = 0; l < 16; l++) chk_line(l, "R2");

    // R1: placement of a few known addresses
    access(1'b0, 11'h7A2, 8'h00, 0);
    access(1'b0, 11'h02E, 8'h00, 0);
    access(1'b0, 11'h02F, 8'h00, 0);
    access(1'b0, 11'h3D5, 8'h00, 0);
    for (int l = 0; l < 16; l++) chk_line(l, "R1");

    // R9: response back-pressure
    access(1'b0, 11'h7A3, 8'h00, 3);

    // R2 / R3 / R4: ascending read sweep of the whole store
    for (int a = 0; a < 2048; a++) access(1'b0, a[10:0], 8'h00, 0);

    // R5 / R6 / R7 / R8: write sweep in odd-stride order
    for (int i = 0; i < 2048; i++) begin
      int a;
      a = (i * 37) & 11'h7FF;
      access(1'b1, a[10:0], 8'((a * 5 + 3) & 8'hFF), 0);
      if ((i & 63) == 0) access(1'b1, a[10:0], 8'(i ^ 8'h5A), 0);
    end
    for (int l = 0; l < 16; l++) chk_line(l, "R10");

    // R7: descending read sweep returns written values
    for (int a = 2047; a >= 0; a--) access(1'b0, a[10:0], 8'h00, 0);
    for (int l = 0; l < 16; l++) chk_line(l, "R8");

    // R9: back-pressure on a write hit
    access(1'b1, 11'h000, 8'hC3, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule